// File: doc/BRIEF.md
# Pseudo-Random Self-Test Signature Engine

This block runs a component-level built-in self-test on a small combinational unit: a 4-bit adder with carry-in. After a start pulse, a maximal-length linear feedback shift register walks through all 15 nonzero states. Each state is spread across the adder's two operands and its carry-in. A multiple-input signature register folds the adder's five output bits (sum and carry-out) into a running 5-bit signature on every pattern cycle.

One cycle after the last pattern, the signature is frozen and compared with a golden value supplied on an input port. A pass/fail tag is raised on mismatch, together with a done flag. The verdict, the flag and the signature stay on the outputs until the next start, so a supervisor can read them at leisure. Loading the golden value from storage is left to the surroundings.

The controller is a four-state machine:
- IDLE goes to RUN on an accepted start (transition LAUNCH).
- RUN stays in RUN for 15 pattern cycles, then goes to CHECK after the fifteenth fold (transition EXHAUST).
- CHECK always goes to DONE after one cycle, and the verdict is registered on that edge (transition JUDGE).
- DONE goes back to RUN on a new start (transition RELAUNCH).

Top module: `sig_bist_engine`

## Requirements
- R1: While reset is asserted and after its release without a start, done, fail_tag, signature and all pattern outputs read zero.
- R2: A start sampled high in IDLE or DONE seeds the generator state s to 4'b0001, clears the signature to zero, and clears done and fail_tag on that same edge.
- R3: In each of the 15 RUN cycles the pattern bus carries pat_x = s, pat_y = {s[1:0], s[3:2]}, pat_cin = s[0]. The state then advances by s' = {s[2:0],0} XOR (s[3] ? 4'b0011 : 0), which gives 15 distinct nonzero values. Outside RUN all pattern outputs are zero.
- R4: On each RUN cycle the signature advances by sig' = {sig[3:0],0} XOR (sig[4] ? 5'b00101 : 0) XOR {rsp_cout, rsp_sum}.
- R5: done rises on the 16th clock edge after the edge that accepted start, which is one edge after the 15th fold; it is low before that.
- R6: When done rises, fail_tag equals 1 exactly when the signature differs from golden as sampled on the judging edge; fail_tag is never 1 while done is 0.
- R7: Once done is high, done, fail_tag and signature hold their values until the next accepted start, whatever golden and the response inputs do.
- R8: A start pulse while the test is running (RUN or CHECK) is ignored: the run length, signature and verdict are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse for a test run |
| pat_x | output | 4 | Operand X driven to the unit under test |
| pat_y | output | 4 | Operand Y driven to the unit under test |
| pat_cin | output | 1 | Carry-in driven to the unit under test |
| rsp_sum | input | 4 | Sum returned by the unit under test |
| rsp_cout | input | 1 | Carry-out returned by the unit under test |
| golden | input | 5 | Expected fault-free signature |
| signature | output | 5 | Current or final compacted signature |
| done | output | 1 | Verdict valid, held until next start |
| fail_tag | output | 1 | Signature mismatch, held until next start |

## Verification
The hardest situation to reach from the ports is a faulty unit, because the engine only sees the adder through its response bus. The bench therefore models the adder itself and adds a stuck-at fault on a chosen output bit (any sum bit or the carry-out), selected at random per run. A second hard case is a start pulse landing mid-run. The bench places one there on purpose and expects the run to finish on the same edge with the same signature. The golden value is also randomized, either the fault-free signature or an arbitrary word, so that both verdicts are reached under both healthy and faulty units.

// File: rtl/sig_bist_pkg.sv
package sig_bist_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_CHECK = 2'd2,
        ST_DONE  = 2'd3
    } bist_state_e;

endpackage

// File: rtl/sig_bist_lfsr.sv
module sig_bist_lfsr #(
    parameter int             W    = 4,
    parameter logic [W-1:0]   TAPS = 4'h3,
    parameter logic [W-1:0]   SEED = 4'h1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    output logic [W-1:0] state
);

    logic [W-1:0] nxt;

    // Galois form: shift towards the MSB, fold the leaving bit back via TAPS
    always_comb begin
        nxt = {state[W-2:0], 1'b0};
        if (state[W-1]) begin
            nxt = nxt ^ TAPS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEED;
        end else if (load) begin
            state <= SEED;
        end else if (step) begin
            state <= nxt;
        end
    end

endmodule

// File: rtl/sig_bist_misr.sv
module sig_bist_misr #(
    parameter int           W    = 5,
    parameter logic [W-1:0] TAPS = 5'h05
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         fold,
    input  logic [W-1:0] din,
    output logic [W-1:0] sig
);

    logic [W-1:0] shifted;

    always_comb begin
        shifted = {sig[W-2:0], 1'b0};
        if (sig[W-1]) begin
            shifted = shifted ^ TAPS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig <= '0;
        end else if (clear) begin
            sig <= '0;
        end else if (fold) begin
            sig <= shifted ^ din;
        end
    end

endmodule

// File: rtl/sig_bist_ctrl.sv
module sig_bist_ctrl
    import sig_bist_pkg::*;
#(
    parameter int PATTERNS = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic decide,
    output logic pat_en,
    output logic running
);

    localparam int CNT_W = $clog2(PATTERNS + 1);

    bist_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             last;

    assign last = (cnt_q == CNT_W'(PATTERNS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // pattern counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // transitions: LAUNCH, EXHAUST, JUDGE, RELAUNCH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_RUN;
            ST_RUN:   if (last)  state_d = ST_CHECK;
            ST_CHECK:            state_d = ST_DONE;
            ST_DONE:  if (start) state_d = ST_RUN;
            default:             state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load    = 1'b0;
        step    = 1'b0;
        decide  = 1'b0;
        pat_en  = 1'b0;
        running = 1'b0;
        unique case (state_q)
            ST_IDLE:  load = start;
            ST_RUN: begin
                step    = 1'b1;
                pat_en  = 1'b1;
                running = 1'b1;
            end
            ST_CHECK: begin
                decide  = 1'b1;
                running = 1'b1;
            end
            ST_DONE:  load = start;
            default:  load = 1'b0;
        endcase
    end

endmodule

// File: rtl/sig_bist_engine.sv
module sig_bist_engine #(
    parameter int                OP_W      = 4,
    parameter logic [OP_W-1:0]   LFSR_TAPS = 4'h3,
    parameter logic [OP_W-1:0]   LFSR_SEED = 4'h1,
    parameter logic [OP_W:0]     MISR_TAPS = 5'h05
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic [OP_W-1:0] pat_x,
    output logic [OP_W-1:0] pat_y,
    output logic            pat_cin,
    input  logic [OP_W-1:0] rsp_sum,
    input  logic            rsp_cout,
    input  logic [OP_W:0]   golden,
    output logic [OP_W:0]   signature,
    output logic            done,
    output logic            fail_tag
);

    localparam int SIG_W    = OP_W + 1;
    localparam int PATTERNS = (1 << OP_W) - 1;
    localparam int HALF     = OP_W / 2;

    logic            load, step, decide, pat_en, run_active;
    logic [OP_W-1:0] gen_state;
    logic [OP_W-1:0] y_rot;
    logic [SIG_W-1:0] sig_q;
    logic            done_q, fail_q;

    sig_bist_ctrl #(.PATTERNS(PATTERNS)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .load    (load),
        .step    (step),
        .decide  (decide),
        .pat_en  (pat_en),
        .running (run_active)
    );

    sig_bist_lfsr #(.W(OP_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .state (gen_state)
    );

    sig_bist_misr #(.W(SIG_W), .TAPS(MISR_TAPS)) u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load),
        .fold  (step),
        .din   ({rsp_cout, rsp_sum}),
        .sig   (sig_q)
    );

    // operand Y is the generator state with its halves swapped
    for (genvar i = 0; i < OP_W; i++) begin : g_rot
        if (i < HALF) begin : g_lo
            assign y_rot[i] = gen_state[i + HALF];
        end else begin : g_hi
            assign y_rot[i] = gen_state[i - HALF];
        end
    end

    assign pat_x   = pat_en ? gen_state    : '0;
    assign pat_y   = pat_en ? y_rot        : '0;
    assign pat_cin = pat_en & gen_state[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
        end else if (load) begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
        end else if (decide) begin
            done_q <= 1'b1;
            fail_q <= (sig_q != golden);
        end
    end

    assign signature = sig_q;
    assign done      = done_q;
    assign fail_tag  = fail_q;

endmodule

// File: rtl/sig_bist_engine_sva.sv
module sig_bist_engine_sva #(
    parameter int OP_W     = 4,
    parameter int PATTERNS = 15
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            running,
    input logic            pat_en,
    input logic [OP_W-1:0] pat_x,
    input logic [OP_W:0]   golden,
    input logic [OP_W:0]   signature,
    input logic            done,
    input logic            fail_tag
);

    localparam int CYC_W = $clog2(PATTERNS + 3) + 1;
    localparam logic [CYC_W-1:0] CYC_MAX = '1;

    logic [CYC_W-1:0] cyc;

    // cycles since the last accepted start, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc <= CYC_MAX;
        end else if (start && !running) begin
            cyc <= '0;
        end else if (cyc != CYC_MAX) begin
            cyc <= cyc + 1'b1;
        end
    end

    p_idle_patterns_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (pat_x == '0));

    p_pattern_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pat_en |-> (pat_x != '0));

    p_clear_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !running) |=> (signature == '0 && !done && !fail_tag));

    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (cyc == CYC_W'(PATTERNS + 1)));

    p_verdict_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (fail_tag == ($past(signature) != $past(golden))));

    p_fail_needs_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fail_tag |-> done);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(signature) && $stable(fail_tag)));

endmodule

bind sig_bist_engine sig_bist_engine_sva #(.OP_W(OP_W), .PATTERNS(PATTERNS)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .running   (run_active),
    .pat_en    (pat_en),
    .pat_x     (pat_x),
    .golden    (golden),
    .signature (signature),
    .done      (done),
    .fail_tag  (fail_tag)
);

// File: tb/sig_bist_engine_tb.sv
`timescale 1ns/1ps
module sig_bist_engine_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] pat_x, pat_y;
    logic       pat_cin;
    logic [3:0] rsp_sum;
    logic       rsp_cout;
    logic [4:0] golden = 5'h0;
    logic [4:0] signature;
    logic       done, fail_tag;

    logic       f_en  = 1'b0;
    logic [2:0] f_bit = 3'd0;
    logic       f_val = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sig_bist_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .pat_x(pat_x), .pat_y(pat_y), .pat_cin(pat_cin),
        .rsp_sum(rsp_sum), .rsp_cout(rsp_cout),
        .golden(golden), .signature(signature),
        .done(done), .fail_tag(fail_tag)
    );

    // unit under test: 4-bit adder with optional stuck-at output bit
    logic [4:0] add_r;
    always_comb begin
        add_r = {1'b0, pat_x} + {1'b0, pat_y} + {4'b0, pat_cin};
        if (f_en) add_r[f_bit] = f_val;
        rsp_sum  = add_r[3:0];
        rsp_cout = add_r[4];
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] gen_next(input logic [3:0] s);
        logic [3:0] t;
        t = {s[2:0], 1'b0};
        if (s[3]) t = t ^ 4'b0011;
        return t;
    endfunction

    function automatic logic [4:0] model_sig(input bit fe, input logic [2:0] fb, input bit fv);
        logic [3:0] s;
        logic [4:0] m, r, sh;
        s = 4'b0001;
        m = 5'h0;
        for (int k = 0; k < 15; k++) begin
            r = {1'b0, s} + {1'b0, s[1:0], s[3:2]} + {4'b0, s[0]};
            if (fe) r[fb] = fv;
            sh = {m[3:0], 1'b0};
            if (m[4]) sh = sh ^ 5'b00101;
            m = sh ^ r;
            s = gen_next(s);
        end
        return m;
    endfunction

    task automatic run_one(input logic [4:0] g, input bit fe, input logic [2:0] fb,
                           input bit fv, input bit mid_start);
        logic [3:0] s;
        logic [4:0] e;
        logic [15:0] seen;
        e = model_sig(fe, fb, fv);
        f_en = fe; f_bit = fb; f_val = fv; golden = g;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(signature == 5'h0 && !done && !fail_tag, "R2 cleared on start",
            {done, fail_tag, signature}, 32'h0);
        s = 4'b0001;
        seen = '0;
        for (int k = 0; k < 15; k++) begin
            chk(pat_x == s && pat_y == {s[1:0], s[3:2]} && pat_cin == s[0], "R3 pattern",
                {pat_x, pat_y, 3'b0, pat_cin}, {s, s[1:0], s[3:2], 3'b0, s[0]});
            seen[pat_x] = 1'b1;
            start = (mid_start && k == 7);   // R8: pulse while running
            s = gen_next(s);
            @(negedge clk);
        end
        start = 1'b0;
        chk(seen == 16'hFFFE, "R3 fifteen distinct nonzero", seen, 32'hFFFE);
        chk(!done && !fail_tag, mid_start ? "R8 run length kept" : "R5 done low before verdict",
            {done, fail_tag}, 32'h0);
        @(negedge clk);
        chk(done == 1'b1, mid_start ? "R8 done on time" : "R5 done rises", done, 32'h1);
        chk(signature == e, "R4 signature", signature, e);
        chk(fail_tag == (e != g), "R6 verdict", fail_tag, (e != g));
        // R7: disturb golden and fault model, outputs must hold
        golden = ~g;
        f_en = ~fe;
        repeat (3) @(negedge clk);
        chk(done && signature == e && fail_tag == (e != g), "R7 hold",
            {done, fail_tag, signature}, {1'b1, (e != g), e});
        chk(pat_x == 4'h0 && pat_y == 4'h0 && !pat_cin, "R3 idle patterns",
            {pat_x, pat_y, pat_cin}, 32'h0);
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (2) @(negedge clk);
        chk(!done && !fail_tag && signature == 5'h0 && pat_x == 4'h0, "R1 in reset",
            {done, fail_tag, signature, pat_x}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!done && !fail_tag && signature == 5'h0 && pat_x == 4'h0 && pat_y == 4'h0 && !pat_cin,
            "R1 after reset", {done, fail_tag, signature, pat_x, pat_y, pat_cin}, 32'h0);

        // directed corners
        run_one(model_sig(1'b0, 3'd0, 1'b0), 1'b0, 3'd0, 1'b0, 1'b0);      // healthy, match
        run_one(~model_sig(1'b0, 3'd0, 1'b0), 1'b0, 3'd0, 1'b0, 1'b0);     // healthy, wrong golden
        run_one(model_sig(1'b0, 3'd0, 1'b0), 1'b1, 3'd0, 1'b0, 1'b0);      // sum0 stuck-at-0
        run_one(model_sig(1'b0, 3'd0, 1'b0), 1'b1, 3'd4, 1'b1, 1'b0);      // carry stuck-at-1
        run_one(model_sig(1'b0, 3'd0, 1'b0), 1'b0, 3'd0, 1'b0, 1'b1);      // start mid-run

        // random runs
        for (int i = 0; i < 24; i++) begin
            bit fe, fv, use_good, ms;
            logic [2:0] fb;
            logic [4:0] g;
            fe = 1'($urandom % 2);
            fb = 3'($urandom % 5);
            fv = 1'($urandom % 2);
            ms = 1'($urandom % 4 == 0);
            use_good = 1'($urandom % 2);
            g = use_good ? model_sig(1'b0, 3'd0, 1'b0) : 5'($urandom);
            run_one(g, fe, fb, fv, ms);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule